// File: doc/BRIEF.md
# Graphics command packet decoder

The block sits behind a command word FIFO and turns its head word into a packet. It reads the opcode from the top byte of the head word and works out from the opcode and its flag bits how many words the whole packet needs. Until the FIFO holds that many words it pops nothing and reports that it is waiting. Once the FIFO holds enough, it pops the whole packet in one cycle, announcing the length, and on the next cycle raises a dispatch strobe. The strobe carries the packet class, the opcode and a fixed setup-cycle cost.

One-word setting packets are handled in the block itself. They write the drawing-environment registers: the clip area corners, the signed drawing offset, the two mask-control bits, the draw-mode word and the texture-window word. A dedicated opcode sets a sticky interrupt-request flag. Drawing, pixel-memory transfers and streaming of polyline vertices past the first two are left to the consumer of the dispatch strobe.

Top module: `cmd_pkt_decoder`

## Requirements
- R1: Opcodes 0x00, 0x03, 0x04 to 0x1E, 0xE0, 0xE7 to 0xEF and 0xFF, and the unknown opcodes 0xF0 to 0xFE, are one-word packets of class no-op (code 0) with cost 0. They change no environment register.
- R2: Opcodes 0x20 to 0x3F are polygons of class render (code 1). Bit 28 is shade, bit 27 is quad and bit 26 is texture. The length is (1+texture+shade) times the vertex count, plus 1 when shade is clear. The vertex count is 4 with quad set and 3 without.
- R3: The polygon cost indexed by {quad,shade,texture} is 46, 226, 334, 496, 82, 262, 370 or 532, for index 0 up to index 7.
- R4: Opcodes 0x40 to 0x5F are lines of class render, 3 words when bit 28 is clear and 4 when it is set. They cost 16 when bit 27 (polyline) is set and 0 otherwise. Opcodes 0x60 to 0x7F are rectangles of class render with cost 16 and length 2+texture, plus 1 when the size field in bits 28:27 is 00.
- R5: Opcode 0x02 is fill (code 2), 3 words. Opcodes 0x80 to 0x9F are copy (code 3), 4 words. Opcodes 0xA0 to 0xDF are copy, 3 words. All of these cost 0.
- R6: While the FIFO count is nonzero but below the packet length, pop_o stays low, waiting_o is high and no dispatch follows.
- R7: When the count reaches the length, pop_o is high with pop_len_o equal to the length in that cycle. One cycle later dispatch_o pulses with the class, opcode and cost of that packet.
- R8: Opcode 0xE3 loads area_left_o from bits 9:0 and area_top_o from bits 19:10. Opcode 0xE4 loads area_right_o and area_bottom_o from the same bits.
- R9: Opcode 0xE5 loads offset_x_o from bits 10:0 and offset_y_o from bits 21:11, each an 11-bit two's-complement value.
- R10: Opcode 0xE6 loads mask_set_o from bit 0 and mask_check_o from bit 1.
- R11: Opcode 0x1F sets irq_o, which then stays set until reset. Opcodes 0x01, 0x1F and 0xE1 to 0xE6 are class setting (code 4) with cost 1. Opcode 0xE1 stores bits 23:0 in draw_mode_o and 0xE2 stores them in tex_window_o.
- R12: After reset, dispatch_o, irq_o and every environment register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_head_i | input | 32 | Word at the FIFO head |
| fifo_count_i | input | 5 | Words held in the FIFO |
| pop_o | output | 1 | Pop a whole packet this cycle |
| pop_len_o | output | 4 | Words to pop |
| waiting_o | output | 1 | FIFO holds a partial packet |
| dispatch_o | output | 1 | Packet dispatch strobe |
| class_o | output | 3 | Packet class code |
| opcode_o | output | 8 | Opcode of the dispatched packet |
| cost_o | output | 10 | Setup-cycle cost |
| irq_o | output | 1 | Sticky interrupt request |
| area_left_o | output | 10 | Clip area left |
| area_top_o | output | 10 | Clip area top |
| area_right_o | output | 10 | Clip area right |
| area_bottom_o | output | 10 | Clip area bottom |
| offset_x_o | output | 11 | Signed drawing offset X |
| offset_y_o | output | 11 | Signed drawing offset Y |
| mask_set_o | output | 1 | Set-mask control |
| mask_check_o | output | 1 | Check-mask control |
| draw_mode_o | output | 24 | Draw-mode word |
| tex_window_o | output | 24 | Texture-window word |

## Verification
A wrong length decode shows at the ports in the same cycle. Either pop_o fires while the FIFO still holds a partial packet, or waiting_o stays high with a full packet present. A wrong class or cost shows on the dispatch strobe one cycle after the pop. An environment register that is loaded from the wrong bits, or that is touched by a packet that should leave it alone, shows on its output from the first edge after the pop and stays wrong until the next setting packet. A lost or cleared interrupt flag shows on irq_o at once and persists.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int WORD_W  = 32;
  localparam int MAX_PKT = 12;
  localparam int LEN_W   = $clog2(MAX_PKT + 1);
  localparam int COST_W  = 10;
  localparam int COORD_W = 10;
  localparam int OFFS_W  = 11;
  localparam int PARM_W  = 24;

  typedef enum logic [2:0] {
    CLS_NOP     = 3'd0,
    CLS_RENDER  = 3'd1,
    CLS_FILL    = 3'd2,
    CLS_COPY    = 3'd3,
    CLS_SETTING = 3'd4
  } pkt_class_e;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    pkt_class_e        cls;
    logic [COST_W-1:0] cost;
  } pkt_info_t;
endpackage

// File: rtl/cpd_len_decode.sv
module cpd_len_decode
  import cpd_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output pkt_info_t         info_o
);
  localparam logic [COST_W-1:0] PRIM_COST = COST_W'(16);
  localparam logic [COST_W-1:0] SET_COST  = COST_W'(1);

  logic [7:0]       op;
  logic             shade, quad, tex;
  logic [LEN_W-1:0] verts, wpv;

  assign op    = word_i[31:24];
  assign shade = word_i[28];
  assign quad  = word_i[27];
  assign tex   = word_i[26];

  function automatic logic [COST_W-1:0] poly_cost(input logic [2:0] k);
    case (k)
      3'd0:    return COST_W'(46);
      3'd1:    return COST_W'(226);
      3'd2:    return COST_W'(334);
      3'd3:    return COST_W'(496);
      3'd4:    return COST_W'(82);
      3'd5:    return COST_W'(262);
      3'd6:    return COST_W'(370);
      default: return COST_W'(532);
    endcase
  endfunction

  always_comb begin
    verts = quad ? LEN_W'(4) : LEN_W'(3);
    wpv   = LEN_W'(1) + LEN_W'(tex) + LEN_W'(shade);
    info_o.len  = LEN_W'(1);
    info_o.cls  = CLS_NOP;
    info_o.cost = '0;
    case (op[7:5])
      3'b000: begin
        if (op == 8'h01 || op == 8'h1F) begin
          info_o.cls  = CLS_SETTING;
          info_o.cost = SET_COST;
        end else if (op == 8'h02) begin
          info_o.cls = CLS_FILL;
          info_o.len = LEN_W'(3);
        end
      end
      3'b001: begin
        info_o.cls  = CLS_RENDER;
        info_o.len  = LEN_W'(wpv * verts) + LEN_W'(!shade);
        info_o.cost = poly_cost({quad, shade, tex});
      end
      3'b010: begin
        info_o.cls  = CLS_RENDER;
        info_o.len  = shade ? LEN_W'(4) : LEN_W'(3);
        info_o.cost = quad ? PRIM_COST : '0;
      end
      3'b011: begin
        info_o.cls  = CLS_RENDER;
        info_o.len  = LEN_W'(2) + LEN_W'(tex) + LEN_W'(word_i[28:27] == 2'b00);
        info_o.cost = PRIM_COST;
      end
      3'b100: begin
        info_o.cls = CLS_COPY;
        info_o.len = LEN_W'(4);
      end
      3'b101, 3'b110: begin
        info_o.cls = CLS_COPY;
        info_o.len = LEN_W'(3);
      end
      default: begin
        if (op >= 8'hE1 && op <= 8'hE6) begin
          info_o.cls  = CLS_SETTING;
          info_o.cost = SET_COST;
        end
      end
    endcase
  end
endmodule

// File: rtl/cpd_env_regs.sv
module cpd_env_regs
  import cpd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [7:0]         op_i,
  input  logic [PARM_W-1:0]  param_i,
  output logic [COORD_W-1:0] area_left_o,
  output logic [COORD_W-1:0] area_top_o,
  output logic [COORD_W-1:0] area_right_o,
  output logic [COORD_W-1:0] area_bottom_o,
  output logic [OFFS_W-1:0]  offset_x_o,
  output logic [OFFS_W-1:0]  offset_y_o,
  output logic               mask_set_o,
  output logic               mask_check_o,
  output logic [PARM_W-1:0]  draw_mode_o,
  output logic [PARM_W-1:0]  tex_window_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      area_left_o   <= '0;
      area_top_o    <= '0;
      area_right_o  <= '0;
      area_bottom_o <= '0;
      offset_x_o    <= '0;
      offset_y_o    <= '0;
      mask_set_o    <= 1'b0;
      mask_check_o  <= 1'b0;
      draw_mode_o   <= '0;
      tex_window_o  <= '0;
    end else if (wr_i) begin
      case (op_i)
        8'hE1: draw_mode_o  <= param_i;
        8'hE2: tex_window_o <= param_i;
        8'hE3: begin
          area_left_o <= param_i[COORD_W-1:0];
          area_top_o  <= param_i[2*COORD_W-1:COORD_W];
        end
        8'hE4: begin
          area_right_o  <= param_i[COORD_W-1:0];
          area_bottom_o <= param_i[2*COORD_W-1:COORD_W];
        end
        8'hE5: begin
          offset_x_o <= param_i[OFFS_W-1:0];
          offset_y_o <= param_i[2*OFFS_W-1:OFFS_W];
        end
        8'hE6: begin
          mask_set_o   <= param_i[0];
          mask_check_o <= param_i[1];
        end
        default: ;
      endcase
    end
  end

  assert_area_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (op_i == 8'hE3)) |=> $stable(area_left_o) && $stable(area_top_o));
  assert_offset_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (op_i == 8'hE5)) |=> offset_y_o == $past(param_i[21:11]));
  assert_mask_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (op_i == 8'hE6)) |=> (mask_set_o == $past(param_i[0])) && (mask_check_o == $past(param_i[1])));
  assert_nop_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_set_o) && $stable(offset_x_o) && $stable(draw_mode_o));
endmodule

// File: rtl/cmd_pkt_decoder.sv
module cmd_pkt_decoder
  import cpd_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        fifo_head_i,
  input  logic [CNT_W-1:0]   fifo_count_i,
  output logic               pop_o,
  output logic [3:0]         pop_len_o,
  output logic               waiting_o,
  output logic               dispatch_o,
  output logic [2:0]         class_o,
  output logic [7:0]         opcode_o,
  output logic [9:0]         cost_o,
  output logic               irq_o,
  output logic [9:0]         area_left_o,
  output logic [9:0]         area_top_o,
  output logic [9:0]         area_right_o,
  output logic [9:0]         area_bottom_o,
  output logic [10:0]        offset_x_o,
  output logic [10:0]        offset_y_o,
  output logic               mask_set_o,
  output logic               mask_check_o,
  output logic [23:0]        draw_mode_o,
  output logic [23:0]        tex_window_o
);
  pkt_info_t info;
  logic      fire, nonempty;

  cpd_len_decode i_len (
    .word_i (fifo_head_i),
    .info_o (info)
  );

  assign nonempty  = fifo_count_i != '0;
  assign fire      = nonempty && (fifo_count_i >= CNT_W'(info.len));
  assign pop_o     = fire;
  assign pop_len_o = info.len;
  assign waiting_o = nonempty && !fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dispatch_o <= 1'b0;
      class_o    <= CLS_NOP;
      opcode_o   <= '0;
      cost_o     <= '0;
      irq_o      <= 1'b0;
    end else begin
      dispatch_o <= fire;
      if (fire) begin
        class_o  <= info.cls;
        opcode_o <= fifo_head_i[31:24];
        cost_o   <= info.cost;
        if (fifo_head_i[31:24] == 8'h1F) irq_o <= 1'b1;
      end
    end
  end

  cpd_env_regs i_env (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (fire),
    .op_i          (fifo_head_i[31:24]),
    .param_i       (fifo_head_i[23:0]),
    .area_left_o   (area_left_o),
    .area_top_o    (area_top_o),
    .area_right_o  (area_right_o),
    .area_bottom_o (area_bottom_o),
    .offset_x_o    (offset_x_o),
    .offset_y_o    (offset_y_o),
    .mask_set_o    (mask_set_o),
    .mask_check_o  (mask_check_o),
    .draw_mode_o   (draw_mode_o),
    .tex_window_o  (tex_window_o)
  );

  assert_len_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> (pop_len_o >= 4'd1) && (pop_len_o <= 4'd12));
  assert_no_partial_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> !waiting_o && (fifo_count_i >= CNT_W'(pop_len_o)));
  assert_dispatch_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> dispatch_o && (opcode_o == $past(fifo_head_i[31:24])));
  assert_no_spurious_dispatch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_o |=> !dispatch_o);
  assert_irq_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> irq_o);
endmodule

// File: tb/test_cmd_pkt_decoder.sv
`timescale 1ns/1ps
module test_cmd_pkt_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] head = '0;
  logic [4:0]  count = '0;
  logic        pop, waiting, dispatch, irq, mset, mchk;
  logic [3:0]  plen;
  logic [2:0]  cls;
  logic [7:0]  opc;
  logic [9:0]  cost, al, at, ar, ab;
  logic [10:0] ox, oy;
  logic [23:0] dmode, twin;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmd_pkt_decoder i_cmd_pkt_decoder (
    .clk_i(clk), .rst_ni(rst_n), .fifo_head_i(head), .fifo_count_i(count),
    .pop_o(pop), .pop_len_o(plen), .waiting_o(waiting), .dispatch_o(dispatch),
    .class_o(cls), .opcode_o(opc), .cost_o(cost), .irq_o(irq),
    .area_left_o(al), .area_top_o(at), .area_right_o(ar), .area_bottom_o(ab),
    .offset_x_o(ox), .offset_y_o(oy), .mask_set_o(mset), .mask_check_o(mchk),
    .draw_mode_o(dmode), .tex_window_o(twin)
  );

  // {word, len, class, cost}
  localparam int NV = 24;
  localparam logic [48:0] VEC [NV] = '{
    {32'h00000000, 4'd1,  3'd0, 10'd0},   // R1
    {32'hFF000000, 4'd1,  3'd0, 10'd0},   // R1
    {32'hF5000000, 4'd1,  3'd0, 10'd0},   // R1 unknown
    {32'h01000000, 4'd1,  3'd4, 10'd1},   // R11
    {32'h02000000, 4'd3,  3'd2, 10'd0},   // R5
    {32'h80000000, 4'd4,  3'd3, 10'd0},   // R5
    {32'hA0000000, 4'd3,  3'd3, 10'd0},   // R5
    {32'hC0000000, 4'd3,  3'd3, 10'd0},   // R5
    {32'h20000000, 4'd4,  3'd1, 10'd46},  // R2 R3
    {32'h24000000, 4'd7,  3'd1, 10'd226},
    {32'h30000000, 4'd6,  3'd1, 10'd334},
    {32'h34000000, 4'd9,  3'd1, 10'd496},
    {32'h28000000, 4'd5,  3'd1, 10'd82},
    {32'h2C000000, 4'd9,  3'd1, 10'd262},
    {32'h38000000, 4'd8,  3'd1, 10'd370},
    {32'h3C000000, 4'd12, 3'd1, 10'd532},
    {32'h40000000, 4'd3,  3'd1, 10'd0},   // R4 lines
    {32'h50000000, 4'd4,  3'd1, 10'd0},
    {32'h48000000, 4'd3,  3'd1, 10'd16},
    {32'h60000000, 4'd3,  3'd1, 10'd16},  // R4 rectangles
    {32'h64000000, 4'd4,  3'd1, 10'd16},
    {32'h68000000, 4'd2,  3'd1, 10'd16},
    {32'h6C000000, 4'd3,  3'd1, 10'd16},
    {32'hE1ABCDEF, 4'd1,  3'd4, 10'd1}    // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // partial count held over an edge, then full packet; samples at negedge
  task automatic run_pkt(input logic [31:0] w, input logic [3:0] len,
                         input logic [2:0] c, input logic [9:0] k);
    @(negedge clk);
    head = w;
    if (len > 1) begin
      count = 5'(len - 1);
      #1 chk("R6 pop while partial", 32'(pop), 0);
      chk("R6 waiting", 32'(waiting), 1);
      @(negedge clk);
      chk("R6 no dispatch", 32'(dispatch), 0);
    end
    count = 5'(len);
    #1 chk("R7 pop", 32'(pop), 1);
    chk("R2 R4 R5 pop_len", 32'(plen), 32'(len));
    @(negedge clk);
    count = '0;
    chk("R7 dispatch", 32'(dispatch), 1);
    chk("R1 R5 class", 32'(cls), 32'(c));
    chk("R7 opcode", 32'(opc), 32'(w[31:24]));
    chk("R3 R4 cost", 32'(cost), 32'(k));
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R12 dispatch", 32'(dispatch), 0);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 area", {al, at, 12'h0}, 0);
    chk("R12 offset", {ox, oy}, 0);
    chk("R12 mode", {dmode, mset, mchk}, 0);

    for (int i = 0; i < NV; i++)
      run_pkt(VEC[i][48:17], VEC[i][16:13], VEC[i][12:10], VEC[i][9:0]);
    chk("R11 draw mode", 32'(dmode), 32'hABCDEF);

    run_pkt(32'hE2123456, 4'd1, 3'd4, 10'd1);
    chk("R11 tex window", 32'(twin), 32'h123456);

    run_pkt(32'hE3000000 | (32'h2AA << 10) | 32'h155, 4'd1, 3'd4, 10'd1);
    chk("R8 left", 32'(al), 32'h155);
    chk("R8 top", 32'(at), 32'h2AA);
    run_pkt(32'hE4000000 | (32'h3FF << 10) | 32'h001, 4'd1, 3'd4, 10'd1);
    chk("R8 right", 32'(ar), 32'h001);
    chk("R8 bottom", 32'(ab), 32'h3FF);

    run_pkt(32'hE5000000 | (32'h3FF << 11) | 32'h7FD, 4'd1, 3'd4, 10'd1);
    chk("R9 offset x", 32'($signed(ox)), 32'hFFFFFFFD);
    chk("R9 offset y", 32'($signed(oy)), 32'd1023);

    run_pkt(32'hE6000001, 4'd1, 3'd4, 10'd1);
    chk("R10 set", 32'(mset), 1);
    chk("R10 check", 32'(mchk), 0);
    run_pkt(32'hE6000002, 4'd1, 3'd4, 10'd1);
    chk("R10 set clr", 32'(mset), 0);
    chk("R10 check set", 32'(mchk), 1);

    // no-op with setting-like parameter bits must leave registers alone
    run_pkt(32'hE0FFFFFF, 4'd1, 3'd0, 10'd0);
    run_pkt(32'hE7FFFFFF, 4'd1, 3'd0, 10'd0);
    chk("R1 area kept", 32'(al), 32'h155);
    chk("R1 mask kept", 32'({mset, mchk}), 32'b01);
    chk("R1 offset kept", 32'(ox), 32'h7FD);

    chk("R11 irq before", 32'(irq), 0);
    run_pkt(32'h1F000000, 4'd1, 3'd4, 10'd1);
    chk("R11 irq set", 32'(irq), 1);
    run_pkt(32'h00000000, 4'd1, 3'd0, 10'd0);
    chk("R11 irq sticky", 32'(irq), 1);

    // empty FIFO: nothing popped, not waiting
    @(negedge clk);
    head = 32'h3C000000;
    count = '0;
    #1 chk("R6 empty no pop", 32'(pop), 0);
    chk("R6 empty not waiting", 32'(waiting), 0);

    // back-to-back one-word packets: dispatch every cycle
    count = 5'd4;
    head = 32'h00000000;
    @(negedge clk);
    chk("R7 back-to-back 1", 32'(dispatch), 1);
    @(negedge clk);
    chk("R7 back-to-back 2", 32'(dispatch), 1);
    count = '0;
    @(negedge clk);
    chk("R7 idle no dispatch", 32'(dispatch), 0);

    // reset clears everything
    rst_n = 1'b0;
    #1 chk("R12 irq after reset", 32'(irq), 0);
    chk("R12 area after reset", 32'(al), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule